// File: doc/BRIEF.md
# Serial Receiver with Status-Tagged Receive Queue

This block receives characters from an asynchronous serial line. The line is sampled 16 times per bit, with a strobe that the surrounding clocking supplies. The receiver accepts characters of 5 to 8 data bits. A character may also carry an address bit, a parity bit and one or two stop bits. Each character is checked for four problems: a framing fault, a parity mismatch, a break condition and an overrun.

The received byte and its four status flags form one 12-bit entry. That entry goes into a small receive queue, or into a single holding slot when queueing is turned off. A consumer reads the oldest entry from a show-ahead read port and pops it with a read strobe. Empty and full flags describe the storage. A one-cycle interrupt pulse announces every stored entry. An entry that carries a break raises the pulse only if break interrupts are enabled.

Configuration inputs are expected to change only while the line is idle and the storage is empty.

Top module: `urx_tagged`

## Requirements
- R1: An entry has this layout: bits [7:0] hold the data byte, received LSB first, with the unused upper bits at zero; bit 8 is the framing flag, bit 9 the parity flag, bit 10 the break flag and bit 11 the overrun flag.
- R2: `cfg_data_len` selects the data length: values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits.
- R3: The framing flag is set when a stop bit is sampled low. With `cfg_two_stop` set, both stop bits are checked, and either one being low sets the flag.
- R4: With `cfg_par_en` set, a parity bit follows the data and any address bit. The parity flag is set when the XOR of the data bits, the address bit and the parity bit differs from `cfg_par_odd` (0 means even parity, 1 means odd parity).
- R5: With `cfg_addr_en` set, one address bit follows the data bits. It is counted in the parity check and is not stored in the entry.
- R6: A character whose data, address, parity and stop bits are all 0 sets the break flag (and also the framing flag). After a break, no further character is taken until the line has returned high.
- R7: A character that completes while the storage is full is discarded. The next entry that is stored carries the overrun flag, and that flag is then cleared.
- R8: With `cfg_fifo_en` set, the storage holds FIFO_DEPTH entries (4 by default). With it clear, the storage holds one entry. `rx_full` and `rx_empty` report the current capacity.
- R9: `rx_irq` pulses for one cycle each time an entry is stored. An entry carrying a break pulses it only when `cfg_brk_irq_en` is set.
- R10: A low on the line that ends before the middle of the start bit is ignored and produces no entry.
- R11: After reset the storage is empty, not full, and `rx_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx_in | input | 1 | Serial line, idles high |
| cfg_data_len | input | 2 | Data length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_addr_en | input | 1 | Address bit present |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_fifo_en | input | 1 | 1 = queue of FIFO_DEPTH entries, 0 = single holding slot |
| cfg_brk_irq_en | input | 1 | Break entries raise the interrupt |
| rd_en | input | 1 | Pop the oldest entry (ignored when empty) |
| rd_data | output | 12 | Oldest entry, in the R1 layout |
| rx_empty | output | 1 | Storage empty |
| rx_full | output | 1 | Storage full at the current capacity |
| rx_irq | output | 1 | One-cycle pulse per stored entry |

## Verification
A line edge passes two synchronizer stages and one idle-detect cycle before the receiver starts counting. Each bit is decided 16 strobes after the previous one, on the third of three samples near its centre. The entry is written one cycle after the last stop bit is decided, and `rx_irq`, `rx_empty` and `rx_full` change on that same edge, about 13 clocks into the final stop bit. The bench drives every bit for 16 clocks from a falling edge. It samples only on falling edges, at least 8 idle clocks after the last stop bit, when the entry is certain to be present. A pop is applied across exactly one rising edge, so the next entry is visible at the following falling edge.

// File: rtl/urx_pkg.sv
// Package: shared entry type and state encoding for the serial receiver.
// Assumes entries are 12 bits: 8 data bits plus 4 status bits.
package urx_pkg;
    localparam int ENTRY_W = 12;

    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } urx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_DONE,
        RX_HOLD
    } urx_state_e;
endpackage

// File: rtl/urx_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    // Shift the line value through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/urx_framer.sv
// Module: start detection, bit timing, majority vote and error evaluation.
// Assumes a synchronized input, and configuration held stable during a character.
// Produces a one-cycle push carrying the byte and the frame/parity/break flags.
module urx_framer
    import urx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxs,
    input  logic [1:0] cfg_dbits,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_addr_en,
    input  logic       cfg_two_stop,
    output logic       push,
    output urx_entry_t entry
);
    localparam int CW       = $clog2(OS_RATE);
    localparam int MAX_BITS = 12;
    localparam int IW       = $clog2(MAX_BITS);
    localparam logic [CW-1:0] HALF = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] S_A  = CW'(OS_RATE - 3);
    localparam logic [CW-1:0] S_B  = CW'(OS_RATE - 2);
    localparam logic [CW-1:0] S_C  = CW'(OS_RATE - 1);

    urx_state_e          state;
    logic [CW-1:0]       os_cnt;
    logic [IW-1:0]       bit_idx;
    logic [MAX_BITS-1:0] frame;
    logic [1:0]          smp;

    logic [IW-1:0] n_data, n_total, addr_pos, par_pos, stop_pos;
    logic          maj, par_calc, brk_det;
    logic [7:0]    dbyte;

    // Derive bit positions from the configured character shape.
    always_comb begin
        n_data   = IW'(5) + IW'(cfg_dbits);
        addr_pos = n_data;
        par_pos  = n_data + IW'(cfg_addr_en);
        stop_pos = par_pos + IW'(cfg_par_en);
        n_total  = stop_pos + IW'(1) + IW'(cfg_two_stop);
    end

    // Two-of-three vote over the samples near the bit centre.
    assign maj = (smp[1] & smp[0]) | (smp[1] & rxs) | (smp[0] & rxs);

    // Extract the data byte and evaluate the status flags from the frame.
    always_comb begin
        for (int i = 0; i < 8; i++)
            dbyte[i] = (i < int'(n_data)) ? frame[i] : 1'b0;
        par_calc    = ^dbyte ^ (cfg_addr_en & frame[addr_pos]);
        brk_det     = (frame == '0);
        entry.data  = dbyte;
        entry.frm   = ~frame[stop_pos] | (cfg_two_stop & ~frame[stop_pos + IW'(1)]);
        entry.par   = cfg_par_en & (par_calc ^ frame[par_pos] ^ cfg_par_odd);
        entry.brk   = brk_det;
        entry.ovr   = 1'b0;
    end

    assign push = (state == RX_DONE);

    // Receive state machine: start validation, bit sampling and break hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            frame   <= '0;
            smp     <= '1;
        end else begin
            case (state)
                RX_IDLE: if (!rxs) begin
                    state  <= RX_START;
                    os_cnt <= '0;
                end
                RX_START: if (tick) begin
                    if (os_cnt == HALF) begin
                        os_cnt  <= '0;
                        bit_idx <= '0;
                        frame   <= '0;
                        state   <= rxs ? RX_IDLE : RX_BITS;
                    end else begin
                        os_cnt <= os_cnt + CW'(1);
                    end
                end
                RX_BITS: if (tick) begin
                    if (os_cnt == S_A) smp[1] <= rxs;
                    if (os_cnt == S_B) smp[0] <= rxs;
                    if (os_cnt == S_C) begin
                        os_cnt         <= '0;
                        frame[bit_idx] <= maj;
                        if (bit_idx == n_total - IW'(1)) state <= RX_DONE;
                        else bit_idx <= bit_idx + IW'(1);
                    end else begin
                        os_cnt <= os_cnt + CW'(1);
                    end
                end
                RX_DONE: state <= brk_det ? RX_HOLD : RX_IDLE;
                RX_HOLD: if (rxs) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/urx_store.sv
// Module: entry storage, either a queue of DEPTH entries or a single slot.
// Tracks a pending overrun and tags the next accepted entry with it.
// Assumes cfg_fifo_en changes only while the storage is empty; DEPTH >= 2.
module urx_store
    import urx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_fifo_en,
    input  logic       push,
    input  urx_entry_t push_entry,
    input  logic       pop_req,
    output urx_entry_t head,
    output logic       empty,
    output logic       full,
    output logic       accept
);
    localparam int AW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    urx_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [NW-1:0] count, cap;
    logic          ovr_pend, pop;
    urx_entry_t    wr_e;

    // Capacity, flags and the entry as it will be written.
    always_comb begin
        cap      = cfg_fifo_en ? NW'(DEPTH) : NW'(1);
        empty    = (count == '0);
        full     = (count >= cap);
        accept   = push & ~full;
        pop      = pop_req & ~empty;
        wr_e     = push_entry;
        wr_e.ovr = ovr_pend;
    end

    assign head = mem[rptr];

    // Entry array write port.
    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_e;
    end

    // Pointers, occupancy and pending overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (accept) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
            if (pop)    rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
            count <= count + NW'(accept) - NW'(pop);
            if (push && full) ovr_pend <= 1'b1;
            else if (accept)  ovr_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/urx_tagged.sv
// Module: top of the serial receiver with status-tagged entry storage.
// Assumes configuration is held stable while a character is in flight.
module urx_tagged
    import urx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               os_tick,
    input  logic               rx_in,
    input  logic [1:0]         cfg_data_len,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_addr_en,
    input  logic               cfg_two_stop,
    input  logic               cfg_fifo_en,
    input  logic               cfg_brk_irq_en,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rx_empty,
    output logic               rx_full,
    output logic               rx_irq
);
    logic       rxs, push, accept;
    urx_entry_t fr_entry, head;

    urx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rxs)
    );

    urx_framer #(.OS_RATE(OS_RATE)) framer_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxs(rxs),
        .cfg_dbits(cfg_data_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_addr_en(cfg_addr_en),
        .cfg_two_stop(cfg_two_stop), .push(push), .entry(fr_entry)
    );

    urx_store #(.DEPTH(FIFO_DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en),
        .push(push), .push_entry(fr_entry), .pop_req(rd_en),
        .head(head), .empty(rx_empty), .full(rx_full), .accept(accept)
    );

    assign rd_data = head;

    // Interrupt pulse on each stored entry; break entries obey their mask.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_irq <= 1'b0;
        else        rx_irq <= accept & (~fr_entry.brk | cfg_brk_irq_en);
    end
endmodule

// File: rtl/urx_tagged_chk.sv
// Module: property checker for the receiver top, attached by bind.
// Assumes cfg_fifo_en changes only while the storage is empty.
module urx_tagged_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_fifo_en,
    input logic rd_en,
    input logic rx_empty,
    input logic rx_full,
    input logic rx_irq
);
    // R8
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

    // R8
    holding_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && !rx_empty) |-> rx_full);

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R9
    irq_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> !rx_empty);

    // R7
    pop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_full) |=> !rx_full);
endmodule

bind urx_tagged urx_tagged_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
);

// File: tb/urx_tagged_tb_top.sv
// Directed bench for the serial receiver: one task per scenario.
module urx_tagged_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic [1:0]  cfg_data_len = 2'd3;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_addr_en = 1'b0;
    logic        cfg_two_stop = 1'b0, cfg_fifo_en = 1'b1, cfg_brk_irq_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        rx_empty, rx_full, rx_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    urx_tagged dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rx_in(rx_in),
        .cfg_data_len(cfg_data_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_addr_en(cfg_addr_en),
        .cfg_two_stop(cfg_two_stop), .cfg_fifo_en(cfg_fifo_en),
        .cfg_brk_irq_en(cfg_brk_irq_en), .rd_en(rd_en), .rd_data(rd_data),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    // Count interrupt pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic idle(input int n);
        rx_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Drive one character, LSB first; the line is left high afterwards.
    task automatic send(input logic [7:0] d, input int nd, input bit use_addr,
                        input bit addr_v, input bit use_par, input bit par_v,
                        input bit two, input bit s1, input bit s2);
        line_bit(1'b0);
        for (int i = 0; i < nd; i++) line_bit(d[i]);
        if (use_addr) line_bit(addr_v);
        if (use_par)  line_bit(par_v);
        line_bit(s1);
        if (two) line_bit(s2);
        idle(12);
    endtask

    task automatic send8(input logic [7:0] d);
        send(d, 8, 0, 0, 0, 0, 0, 1, 1);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 empty", 12'(rx_empty), 12'd1);
        chk("R11 full", 12'(rx_full), 12'd0);
        chk("R11 irq", 12'(rx_irq), 12'd0);
    endtask

    task automatic t_basic();
        int i0;
        i0 = irq_cnt;
        send8(8'hA5);
        chk("R1 byte A5", rd_data, 12'h0A5);
        chk("R9 one pulse", 12'(irq_cnt - i0), 12'd1);
        pop();
        send8(8'h3C);
        chk("R1 byte 3C", rd_data, 12'h03C);
        pop();
        chk("R1 drained", 12'(rx_empty), 12'd1);
    endtask

    task automatic t_width();
        cfg_data_len = 2'd0;
        send(8'hF6, 5, 0, 0, 0, 0, 0, 1, 1);
        chk("R2 five bits", rd_data, 12'h016);
        pop();
        cfg_data_len = 2'd2;
        send(8'hDA, 7, 0, 0, 0, 0, 0, 1, 1);
        chk("R2 seven bits", rd_data, 12'h05A);
        pop();
        cfg_data_len = 2'd3;
    endtask

    task automatic t_parity();
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        send(8'hA5, 8, 0, 0, 1, 0, 0, 1, 1);
        chk("R4 even ok", rd_data, 12'h0A5);
        pop();
        send(8'hA5, 8, 0, 0, 1, 1, 0, 1, 1);
        chk("R4 even bad", rd_data, 12'h2A5);
        pop();
        cfg_par_odd = 1'b1;
        send(8'hA5, 8, 0, 0, 1, 1, 0, 1, 1);
        chk("R4 odd ok", rd_data, 12'h0A5);
        pop();
        send(8'hA5, 8, 0, 0, 1, 0, 0, 1, 1);
        chk("R4 odd bad", rd_data, 12'h2A5);
        pop();
        cfg_par_odd = 1'b0;
    endtask

    task automatic t_addr();
        cfg_addr_en = 1'b1;
        send(8'h01, 8, 1, 1, 1, 0, 0, 1, 1);
        chk("R5 addr in parity ok", rd_data, 12'h001);
        pop();
        send(8'h01, 8, 1, 1, 1, 1, 0, 1, 1);
        chk("R5 addr in parity bad", rd_data, 12'h201);
        pop();
        cfg_addr_en = 1'b0;
        cfg_par_en = 1'b0;
    endtask

    task automatic t_frame();
        send(8'h55, 8, 0, 0, 0, 0, 0, 0, 1);
        chk("R3 single stop low", rd_data, 12'h155);
        pop();
        cfg_two_stop = 1'b1;
        send(8'h55, 8, 0, 0, 0, 0, 1, 1, 0);
        chk("R3 second stop low", rd_data, 12'h155);
        pop();
        send(8'h55, 8, 0, 0, 0, 0, 1, 0, 1);
        chk("R3 first stop low", rd_data, 12'h155);
        pop();
        send(8'h55, 8, 0, 0, 0, 0, 1, 1, 1);
        chk("R3 both stops high", rd_data, 12'h055);
        pop();
        chk("R3 no extra entry", 12'(rx_empty), 12'd1);
        cfg_two_stop = 1'b0;
    endtask

    task automatic brk_char(input bit irq_en, input string tag);
        int i0;
        cfg_brk_irq_en = irq_en;
        i0 = irq_cnt;
        rx_in = 1'b0;
        repeat (BIT_CLKS * 10 + 64) @(negedge clk);
        idle(32);
        chk({tag, " entry"}, rd_data, 12'h500);
        chk({tag, " irq"}, 12'(irq_cnt - i0), irq_en ? 12'd1 : 12'd0);
        pop();
        chk({tag, " single entry"}, 12'(rx_empty), 12'd1);
    endtask

    task automatic t_break();
        brk_char(1'b0, "R6 break masked");
        brk_char(1'b1, "R9 break enabled");
        cfg_brk_irq_en = 1'b0;
    endtask

    task automatic t_ovr_single();
        int i0;
        cfg_fifo_en = 1'b0;
        send8(8'h11);
        chk("R8 slot full", 12'(rx_full), 12'd1);
        i0 = irq_cnt;
        send8(8'h22);
        chk("R7 dropped keeps head", rd_data, 12'h011);
        chk("R9 no pulse on drop", 12'(irq_cnt - i0), 12'd0);
        pop();
        chk("R8 slot empty", 12'(rx_empty), 12'd1);
        send8(8'h33);
        chk("R7 overrun tagged", rd_data, 12'h833);
        pop();
        send8(8'h34);
        chk("R7 overrun cleared", rd_data, 12'h034);
        pop();
        cfg_fifo_en = 1'b1;
    endtask

    task automatic t_ovr_fifo();
        for (int i = 0; i < 4; i++) begin
            send8(8'h41 + 8'(i));
            if (i < 3) chk("R8 not full early", 12'(rx_full), 12'd0);
        end
        chk("R8 queue full", 12'(rx_full), 12'd1);
        send8(8'h45);
        for (int i = 0; i < 4; i++) begin
            chk("R8 queue order", rd_data, 12'h041 + 12'(i));
            pop();
        end
        chk("R8 queue empty", 12'(rx_empty), 12'd1);
        send8(8'h46);
        chk("R7 queue overrun tag", rd_data, 12'h846);
        pop();
    endtask

    task automatic t_glitch();
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        idle(60);
        chk("R10 short low ignored", 12'(rx_empty), 12'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(20);
        t_basic();
        t_width();
        t_parity();
        t_addr();
        t_frame();
        t_break();
        t_ovr_single();
        t_ovr_fifo();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule